// File: doc/BRIEF.md
# Block Transfer Sequencer

This block moves a group of registers between a register file and a word-addressed memory with a single command. The command carries four things: a bit mask that picks any subset of the register file, a base address, a direction (load from memory or store to memory) and one of four addressing modes. It can also ask for the base register to be updated. Once started, the sequencer makes one word access per cycle. Registers are always handled from the lowest number to the highest, and consecutive registers use addresses that rise by 4.

When the last access has finished, the sequencer can write the final address back into a chosen register. It then pulses `done`. The memory port is synchronous: read data appears on the cycle after the request. The register file has one combinational read port and one write port that commits on the clock edge.

Top module: `lsm_sequencer`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `mem_req` and `rf_we` are all low.
- R2: For a non-empty mask, the cycle after `start` begins one access per cycle, one for each selected register, with no gaps. Registers are served in ascending register number, whatever the mask bit pattern, and `rf_raddr` names the register being served.
- R3: A store (`is_load`=0) drives `mem_we`=1 and puts the value read from `rf_raddr` on `mem_wdata`. Memory ends up holding the selected registers in ascending order at ascending word addresses.
- R4: A load (`is_load`=1) takes the word returned one cycle after each read request and writes it to that access's register in that same cycle. The selected registers end up holding consecutive memory words.
- R5: `mode` encoding and first address, with n the number of selected registers: 0 = increment-after, first address is base. 1 = increment-before, first address is base+4. 2 = decrement-after, first address is base−4n+4. 3 = decrement-before, first address is base−4n. Each later access adds 4.
- R6: When `wb_en` is set and the mask is not empty, the base register `base_reg` receives base+4n (modes 0 and 1) or base−4n (modes 2 and 3). This happens once, in a cycle of its own after the last transfer and its load write. It overrides a value loaded into the same register.
- R7: An empty mask makes no memory access and no register write, and it raises `done` on the next cycle.
- R8: `done` is a one-cycle pulse with `busy` low. For n>0 it comes n+1 cycles after `start`, plus one cycle for a load and one for a writeback. `busy` stays high from the cycle after `start` until `done`.
- R9: `start` is ignored while `busy` is high. The running command completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command strobe, accepted when not busy |
| is_load | input | 1 | 1 = memory to registers, 0 = registers to memory |
| mode | input | 2 | Addressing mode (see R5) |
| wb_en | input | 1 | Write the final address to `base_reg` |
| reg_list | input | NREGS | Register select mask |
| base_reg | input | IW | Register that receives the writeback |
| base_addr | input | XLEN | Base byte address |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | XLEN | Byte address of the access |
| mem_wdata | output | XLEN | Store data |
| mem_rdata | input | XLEN | Read data, one cycle after the request |
| rf_raddr | output | IW | Register file read index |
| rf_rdata | input | XLEN | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | IW | Register file write index |
| rf_wdata | output | XLEN | Register file write data |

## Verification
The bench builds the block with its defaults: 16 registers and 32-bit words. With 16 registers, a full mask gives the longest burst of 16 accesses, and sparse masks with a high bit set exercise the priority pick across the whole width. Base addresses sit in a 256-word window, so all four modes reach both below and above the base without leaving the modelled memory. The cases include the base register appearing inside a loaded list, and a second `start` arriving mid-burst.

// File: rtl/lsm_pkg.sv
// Package: shared encodings for the block transfer sequencer.
// Assumes: mode bit 1 selects decrement, mode bit 0 selects "before".
package lsm_pkg;
    typedef enum logic [1:0] {
        AM_INC_AFTER  = 2'b00,
        AM_INC_BEFORE = 2'b01,
        AM_DEC_AFTER  = 2'b10,
        AM_DEC_BEFORE = 2'b11
    } addr_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_XFER  = 3'd1,
        ST_DRAIN = 3'd2,
        ST_WBACK = 3'd3,
        ST_FIN   = 3'd4
    } seq_state_e;

    localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/lsm_low_pick.sv
// Module: lsm_low_pick
// Finds the lowest set bit of a mask and reports it both as an index and as
// a one-hot vector. Built as a ripple "any lower bit set" chain.
// Assumes: N >= 2, IW = $clog2(N).
module lsm_low_pick #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  mask,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);
    logic [N:0] lower_any;

    assign lower_any[0] = 1'b0;

    // Prefix chain: a bit is granted only if no lower bit is set.
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign lower_any[i+1] = lower_any[i] | mask[i];
        assign onehot[i]      = mask[i] & ~lower_any[i];
    end

    assign found = lower_any[N];

    // Encode the one-hot grant into a binary index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) idx = idx | IW'(i);
        end
    end

    // Lowest pick is a member of the mask, and there is at most one grant.
    assert_pick_member_R2: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> mask[idx]);
    assert_pick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(onehot));
endmodule

// File: rtl/lsm_popcount.sv
// Module: lsm_popcount
// Counts the set bits of the register mask.
// Assumes: CW wide enough to hold N.
module lsm_popcount #(
    parameter int N  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  bits,
    output logic [CW-1:0] count
);
    // Sum all bits of the mask.
    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + CW'(bits[i]);
        end
    end
endmodule

// File: rtl/lsm_addr_calc.sv
// Module: lsm_addr_calc
// Works out the first access address and the writeback address from the base,
// the transfer count and the addressing mode. The lowest register always gets
// the lowest address, so the first address is the bottom of the block.
// Assumes: word size of 4 bytes; address arithmetic wraps modulo 2^XLEN.
module lsm_addr_calc
    import lsm_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CW   = 5
) (
    input  logic [XLEN-1:0] base,
    input  logic [CW-1:0]   count,
    input  addr_mode_e      mode,
    output logic [XLEN-1:0] first_addr,
    output logic [XLEN-1:0] final_addr
);
    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

    logic [XLEN-1:0] span;

    assign span = XLEN'(count) << 2;

    // Select the bottom-of-block address for each mode.
    always_comb begin
        unique case (mode)
            AM_INC_AFTER:  first_addr = base;
            AM_INC_BEFORE: first_addr = base + STEP;
            AM_DEC_AFTER:  first_addr = base - span + STEP;
            default:       first_addr = base - span;
        endcase
    end

    // Updated base: moves by the whole block in the mode's direction.
    always_comb begin
        if (mode[1]) final_addr = base - span;
        else         final_addr = base + span;
    end
endmodule

// File: rtl/lsm_sequencer.sv
// Module: lsm_sequencer (top)
// Runs one block transfer between register file and memory: one word access
// per cycle in ascending register order, an extra cycle to land the last load,
// an optional base writeback cycle, then a one-cycle done pulse.
// Assumes: memory read data arrives one cycle after the request; register file
// read is combinational and its write commits on the clock edge.
module lsm_sequencer
    import lsm_pkg::*;
#(
    parameter int NREGS = 16,
    parameter int XLEN  = 32,
    localparam int IW   = $clog2(NREGS),
    localparam int CW   = $clog2(NREGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_load,
    input  logic [1:0]       mode,
    input  logic             wb_en,
    input  logic [NREGS-1:0] reg_list,
    input  logic [IW-1:0]    base_reg,
    input  logic [XLEN-1:0]  base_addr,
    output logic             busy,
    output logic             done,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic [IW-1:0]    rf_raddr,
    input  logic [XLEN-1:0]  rf_rdata,
    output logic             rf_we,
    output logic [IW-1:0]    rf_waddr,
    output logic [XLEN-1:0]  rf_wdata
);
    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

    seq_state_e       state_q;
    logic [NREGS-1:0] mask_q;
    logic [XLEN-1:0]  addr_q;
    logic [XLEN-1:0]  final_q;
    logic [IW-1:0]    breg_q;
    logic             load_q;
    logic             wb_q;
    logic             ld_pend_q;
    logic [IW-1:0]    ld_idx_q;

    logic             pick_found;
    logic [IW-1:0]    pick_idx;
    logic [NREGS-1:0] pick_oh;
    logic [NREGS-1:0] mask_next;
    logic [CW-1:0]    sel_count;
    logic [XLEN-1:0]  calc_first;
    logic [XLEN-1:0]  calc_final;
    logic             accept;

    lsm_low_pick #(.N(NREGS), .IW(IW)) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .mask   (mask_q),
        .found  (pick_found),
        .idx    (pick_idx),
        .onehot (pick_oh)
    );

    lsm_popcount #(.N(NREGS), .CW(CW)) u_count (
        .bits  (reg_list),
        .count (sel_count)
    );

    lsm_addr_calc #(.XLEN(XLEN), .CW(CW)) u_addr (
        .base       (base_addr),
        .count      (sel_count),
        .mode       (addr_mode_e'(mode)),
        .first_addr (calc_first),
        .final_addr (calc_final)
    );

    assign accept    = start && (state_q == ST_IDLE || state_q == ST_FIN);
    assign mask_next = mask_q & ~pick_oh;

    // Control sequence and command capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
            addr_q  <= '0;
            final_q <= '0;
            breg_q  <= '0;
            load_q  <= 1'b0;
            wb_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_FIN: begin
                    if (accept) begin
                        mask_q  <= reg_list;
                        addr_q  <= calc_first;
                        final_q <= calc_final;
                        breg_q  <= base_reg;
                        load_q  <= is_load;
                        wb_q    <= wb_en;
                        state_q <= (reg_list == '0) ? ST_FIN : ST_XFER;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_XFER: begin
                    mask_q <= mask_next;
                    addr_q <= addr_q + STEP;
                    if (mask_next == '0) begin
                        if (load_q)    state_q <= ST_DRAIN;
                        else if (wb_q) state_q <= ST_WBACK;
                        else           state_q <= ST_FIN;
                    end
                end
                ST_DRAIN: state_q <= wb_q ? ST_WBACK : ST_FIN;
                ST_WBACK: state_q <= ST_FIN;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Load return pipeline: remembers which register the pending read data targets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_pend_q <= 1'b0;
            ld_idx_q  <= '0;
        end else begin
            ld_pend_q <= (state_q == ST_XFER) && load_q;
            ld_idx_q  <= pick_idx;
        end
    end

    // Port drive from the current state.
    always_comb begin
        busy      = (state_q == ST_XFER) || (state_q == ST_DRAIN) || (state_q == ST_WBACK);
        done      = (state_q == ST_FIN);
        mem_req   = (state_q == ST_XFER) && pick_found;
        mem_we    = mem_req && !load_q;
        mem_addr  = addr_q;
        mem_wdata = rf_rdata;
        rf_raddr  = pick_idx;
        rf_we     = ld_pend_q || (state_q == ST_WBACK);
        rf_waddr  = (state_q == ST_WBACK) ? breg_q : ld_idx_q;
        rf_wdata  = (state_q == ST_WBACK) ? final_q : mem_rdata;
    end

    // Accesses happen only inside a busy window.
    assert_req_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
    // Back-to-back accesses climb in both register number and address.
    assert_order_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> (rf_raddr > $past(rf_raddr)));
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + STEP));
    // Writeback never collides with a landing load.
    assert_wb_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_pend_q && state_q == ST_WBACK));
    // An empty mask finishes next cycle without touching memory.
    assert_empty_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && reg_list == '0) |=> (done && !mem_req && !rf_we));
    // Done is exclusive with busy and with any access.
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mem_req));
    // A running command keeps its captured writeback target.
    assert_hold_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(breg_q));
endmodule

// File: tb/sim_lsm_sequencer.sv
module sim_lsm_sequencer;
    localparam int NREGS = 16;
    localparam int XLEN  = 32;
    localparam int IW    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             is_load = 1'b0;
    logic [1:0]       mode = 2'd0;
    logic             wb_en = 1'b0;
    logic [NREGS-1:0] reg_list = '0;
    logic [IW-1:0]    base_reg = '0;
    logic [XLEN-1:0]  base_addr = '0;
    logic             busy, done, mem_req, mem_we, rf_we;
    logic [XLEN-1:0]  mem_addr, mem_wdata, rf_wdata, rf_rdata;
    logic [XLEN-1:0]  mem_rdata = '0;
    logic [IW-1:0]    rf_raddr, rf_waddr;

    logic [XLEN-1:0] mem [0:255];
    logic [XLEN-1:0] rf  [0:NREGS-1];
    logic [XLEN-1:0] exp_mem [0:255];
    logic [XLEN-1:0] exp_rf  [0:NREGS-1];

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lsm_sequencer #(.NREGS(NREGS), .XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .is_load(is_load), .mode(mode),
        .wb_en(wb_en), .reg_list(reg_list), .base_reg(base_reg), .base_addr(base_addr),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    // Environment: synchronous memory and register file.
    assign rf_rdata = rf[rf_raddr];
    always @(posedge clk) begin
        if (mem_req && mem_we)  mem[mem_addr[9:2]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
        if (rf_we)              rf[rf_waddr] <= rf_wdata;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int popc(input logic [NREGS-1:0] m);
        int c = 0;
        for (int i = 0; i < NREGS; i++) c += int'(m[i]);
        return c;
    endfunction

    // First access address from R5.
    function automatic logic [XLEN-1:0] first_of(input logic [1:0] md, input logic [XLEN-1:0] b, input int n);
        case (md)
            2'd0: return b;
            2'd1: return b + 4;
            2'd2: return b - 32'(4 * n) + 4;
            default: return b - 32'(4 * n);
        endcase
    endfunction

    // Writeback value from R6.
    function automatic logic [XLEN-1:0] final_of(input logic [1:0] md, input logic [XLEN-1:0] b, input int n);
        return md[1] ? b - 32'(4 * n) : b + 32'(4 * n);
    endfunction

    task automatic run_op(input bit ld, input logic [1:0] md, input bit wb,
                          input logic [NREGS-1:0] lst, input logic [IW-1:0] br,
                          input logic [XLEN-1:0] b, input bit intrude);
        int n = popc(lst);
        logic [XLEN-1:0] fa = first_of(md, b, n);
        logic [NREGS-1:0] left = lst;
        int k = 0, acc = 0, cyc = 0, lat, bad_m = 0, bad_r = 0, got_lat = -1;
        bit busy_ok = 1'b1;
        lat = (n == 0) ? 1 : n + 1 + int'(ld) + int'(wb);
        for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
        for (int r = 0; r < NREGS; r++) exp_rf[r] = rf[r];
        for (int r = 0; r < NREGS; r++) begin
            if (lst[r]) begin
                logic [XLEN-1:0] a = fa + 32'(4 * k);
                if (ld) exp_rf[r] = mem[a[9:2]];
                else    exp_mem[a[9:2]] = rf[r];
                k++;
            end
        end
        if (wb && n > 0) exp_rf[br] = final_of(md, b, n);

        @(negedge clk);
        start = 1'b1; is_load = ld; mode = md; wb_en = wb;
        reg_list = lst; base_reg = br; base_addr = b;
        while (cyc < 100) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin
                start = intrude && (n > 0);
                reg_list = '1; base_reg = br + 1; mode = ~md; is_load = ~ld;
            end else begin
                start = 1'b0;
            end
            if (done) begin got_lat = cyc; break; end
            if (!busy) busy_ok = 1'b0;
            if (mem_req) begin
                int want = -1;
                for (int r = 0; r < NREGS; r++) if (left[r] && want < 0) want = r;
                chk(want >= 0 && rf_raddr == IW'(want), "R2 order", rf_raddr, want);
                chk(mem_addr == fa + 32'(4 * acc), "R5 address", mem_addr, fa + 32'(4 * acc));
                chk(mem_we == !ld, ld ? "R4 read" : "R3 write", mem_we, !ld);
                if (want >= 0) left[want] = 1'b0;
                acc++;
            end
        end
        start = 1'b0;
        chk(got_lat == lat, (n == 0) ? "R7 latency" : "R8 latency", got_lat, lat);
        chk(busy == 1'b0, "R8 busy at done", busy, 0);
        chk(busy_ok, "R8 busy window", busy_ok, 1);
        chk(acc == n, (n == 0) ? "R7 no access" : "R2 access count", acc, n);
        @(negedge clk);
        chk(done == 1'b0, "R8 pulse", done, 0);
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad_m++;
        for (int r = 0; r < NREGS; r++) if (rf[r] !== exp_rf[r]) bad_r++;
        chk(bad_m == 0, intrude ? "R9 memory" : "R3 memory", bad_m, 0);
        chk(bad_r == 0, wb ? "R6 registers" : "R4 registers", bad_r, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 256; i++) mem[i] = $urandom;
        for (int r = 0; r < NREGS; r++) rf[r] = $urandom;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req && !rf_we, "R1 reset", {busy, done, mem_req, rf_we}, 0);

        // Directed: each mode, both directions, sparse list.
        for (int m = 0; m < 4; m++) begin
            run_op(1'b0, 2'(m), 1'b1, 16'h8012, 4'd3, 32'h200, 1'b0);
            run_op(1'b1, 2'(m), 1'b1, 16'h8012, 4'd3, 32'h200, 1'b0);
        end
        run_op(1'b0, 2'd0, 1'b1, 16'h0000, 4'd2, 32'h200, 1'b0);  // R7
        run_op(1'b1, 2'd3, 1'b0, 16'h0000, 4'd2, 32'h200, 1'b0);  // R7
        run_op(1'b0, 2'd1, 1'b0, 16'hFFFF, 4'd0, 32'h180, 1'b0);  // full list
        run_op(1'b1, 2'd2, 1'b1, 16'hFFFF, 4'd5, 32'h280, 1'b0);  // R6 base loaded then overridden
        run_op(1'b1, 2'd0, 1'b1, 16'h0021, 4'd5, 32'h240, 1'b0);  // R6
        run_op(1'b0, 2'd0, 1'b0, 16'h0001, 4'd1, 32'h204, 1'b1);  // R9 single
        run_op(1'b1, 2'd3, 1'b1, 16'h0F0F, 4'd9, 32'h2C0, 1'b1);  // R9

        // Random commands.
        for (int t = 0; t < 150; t++) begin
            logic [NREGS-1:0] lst = 16'($urandom);
            if (t % 7 == 0) lst = '0;
            run_op(1'($urandom), 2'($urandom), 1'($urandom), lst, 4'($urandom),
                   32'h200 + {24'd0, 6'($urandom), 2'b00}, 1'($urandom));
        end
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule